// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block makes a plain synchronous design look like a serial EEPROM on a two-wire I2C bus. Both bus lines are brought into the fast system clock domain through flip-flop synchronisers. Edge detection on the synchronised lines recognises start and stop conditions and the clock edges of each bit. The block keeps a parameterised byte array and a single address pointer. It answers byte writes, page writes, random reads and current-address reads. It answers only through a pull-low enable for the SDA pad.

A master selects the device with a 7-bit address. The first four bits are a fixed device-type code and the last three come from board straps. After a write-direction address, the master sends a two-byte word address and then the data. A write-protect input can lock the upper half of the array. A status output shows standby between a stop and the next start.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Before the first start condition, the slave ignores the bus and gives no ACK. A start is SDA falling while SCL is high. Any start, including a repeated start in the middle of a byte, sends the slave back to address reception with its bit count cleared.
- R2: The slave ACKs the address byte only when its upper seven bits, MSB first, equal 1010 followed by strap_i[2:0]. On a mismatch it gives no ACK and ignores the rest of the transaction until the next start.
- R3: Bit 0 of the address byte sets the direction, with 1 for read and 0 for write. A read address with no word address reads from the current pointer.
- R4: After a write address, the slave ACKs a high and then a low word-address byte. Word-address bits above the array width are ignored. Each later data byte is ACKed and stored at the pointer.
- R5: During a write, only the low five pointer bits advance after each byte. They wrap inside the current 32-byte page, and the upper pointer bits never change.
- R6: While wp_i is high and the pointer's top bit is 1, a data byte gets NACK and is not stored. The address byte and both word-address bytes are still ACKed. Lower-half writes and all reads are unaffected.
- R7: Read data goes out MSB first. The pointer advances over the full array after each byte and wraps from the last location to 0. A master ACK continues the read. A master NACK ends it and leaves SDA released.
- R8: sda_pull_o changes only while SCL is low.
- R9: SDA is never driven high. sda_pull_o is 0 after reset and whenever the slave is neither ACKing nor sending a 0 bit.
- R10: standby_o is 1 after reset and after a stop (SDA rising while SCL is high). It goes to 0 at a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Board strap bits of the slave address |
| wp_i | input | 1 | Write-protect for the upper half of the array |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| standby_o | output | 1 | 1 between a stop and the next start |

## Verification
Every array location is first filled with a value computed from its own address, using page writes. A single sequential read of one byte more than the array then checks storage, the pointer order and the wrap to address 0 together. Page writes that start two bytes before a page boundary show whether the pointer wraps inside the page or carries into the next one. Reads at the wrapped and unwrapped locations tell the two apart. Foreign device-type codes, foreign strap values and a byte clocked in before any start must all go unanswered. Protected and unprotected writes under an asserted write-protect separate the address-range check from a global write inhibit. A repeated start cut into the middle of a byte confirms that the bit count restarts.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WAH,
    ST_WAL,
    ST_WDAT,
    ST_RDAT
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [0] newest sample, [STAGES-1] synchronised level, [STAGES] previous level
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_prev   = scl_q[STAGES];
  assign sda_prev   = sda_q[STAGES];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o,
  output logic       standby_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start, stop;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_lvl),
    .sda_o      (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  ee_state_e     state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    rx_q, tx_q, hi_q, rd_data;
  logic [AW-1:0] ptr_q, page_next, word_ptr;
  logic          pull_q, standby_q, mack_q;
  logic          dev_match, wp_block, byte_end, mem_we;
  logic [15:0]   word_full;
  logic          unused_hi;

  assign dev_match = rx_q[7:1] == {DEV_TYPE, strap_i};
  assign wp_block  = wp_i & ptr_q[AW-1];
  assign byte_end  = scl_fall && bit_cnt_q == 4'd8;
  assign mem_we    = state_q == ST_WDAT && byte_end && !wp_block;
  assign word_full = {hi_q, rx_q};
  assign word_ptr  = word_full[AW-1:0];
  assign unused_hi = ^word_full[15:AW];
  assign page_next = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};

  i2c_ee_mem #(.DEPTH(MEM_BYTES), .DW(8)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (ptr_q),
    .wdata_i (rx_q),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      hi_q      <= '0;
      ptr_q     <= '0;
      pull_q    <= 1'b0;
      standby_q <= 1'b1;
      mack_q    <= 1'b0;
    end else if (start) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      pull_q    <= 1'b0;
      standby_q <= 1'b0;
    end else if (stop) begin
      state_q   <= ST_IDLE;
      pull_q    <= 1'b0;
      standby_q <= 1'b1;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt_q != 4'd9) bit_cnt_q <= bit_cnt_q + 4'd1;
        if (bit_cnt_q < 4'd8) rx_q <= {rx_q[6:0], sda_lvl};
        // 9th clock: low line means ACK (own ACK on the address of a read)
        if (bit_cnt_q == 4'd8) mack_q <= ~sda_lvl;
      end
      if (scl_fall) begin
        if (bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          pull_q    <= 1'b0;
          if (state_q == ST_RDAT) begin
            if (mack_q) begin
              tx_q   <= rd_data;
              pull_q <= ~rd_data[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end else if (bit_cnt_q == 4'd8) begin
          unique case (state_q)
            ST_DEV: begin
              if (dev_match) begin
                pull_q  <= 1'b1;
                state_q <= rx_q[0] ? ST_RDAT : ST_WAH;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_WAH: begin
              hi_q    <= rx_q;
              pull_q  <= 1'b1;
              state_q <= ST_WAL;
            end
            ST_WAL: begin
              ptr_q   <= word_ptr;
              pull_q  <= 1'b1;
              state_q <= ST_WDAT;
            end
            ST_WDAT: begin
              if (!wp_block) begin
                pull_q <= 1'b1;
                ptr_q  <= page_next;
              end
            end
            ST_RDAT: begin
              pull_q <= 1'b0;
              ptr_q  <= ptr_q + AW'(1);
            end
            default: ;
          endcase
        end else if (state_q == ST_RDAT && bit_cnt_q != 4'd0) begin
          pull_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
        end
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign standby_o  = standby_q;

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_lvl); // R8
  AST_START_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_DEV && bit_cnt_q == 4'd0 && !standby_o)); // R1
  AST_FOREIGN_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV && byte_end && !dev_match) |=> (!sda_pull_o && state_q == ST_IDLE)); // R2
  AST_WP_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDAT && byte_end && wp_i && ptr_q[AW-1]) |=> (!sda_pull_o && $stable(ptr_q))); // R6
  AST_PAGE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])); // R5
  AST_STOP_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (standby_o && !sda_pull_o)); // R10
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int         Q     = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp_i = 1'b0;
  logic sda_pull_o, standby_o, sda_line;
  int   checks = 0, errors = 0, r8_bad = 0;
  logic [7:0] model [256];

  always #4 clk_i = ~clk_i;
  assign sda_line = sda_m & ~sda_pull_o;

  i2c_eeprom_slave u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (STRAP),
    .wp_i       (wp_i),
    .sda_pull_o (sda_pull_o),
    .standby_o  (standby_o)
  );

  // R8: pull enable may change only while SCL is low
  always @(sda_pull_o) if (rst_ni && scl_m) r8_bad++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_c;
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic stop_c;
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] d0,
                          input logic [7:0] step, input bit exp_ack, input string tag);
    bit ack;
    logic [7:0] d, ad;
    start_c;
    chk(standby_o == 1'b0, "R10", standby_o, 0);
    send_byte(DEV_W, ack); chk(ack, "R2", ack, 1);
    send_byte(a[15:8], ack); chk(ack, "R4", ack, 1);
    send_byte(a[7:0], ack); chk(ack, "R4", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(d0 + i * step);
      send_byte(d, ack);
      chk(ack == exp_ack, tag, ack, exp_ack);
      if (exp_ack) begin
        ad = {a[7:5], 5'(a[4:0] + i)};
        model[ad] = d;
      end
    end
    stop_c;
    chk(standby_o == 1'b1, "R10", standby_o, 1);
  endtask

  task automatic read_tail(input logic [7:0] a, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == model[8'(a + i)], "R7", d, model[8'(a + i)]);
    end
    tick(Q);
    chk(sda_pull_o == 1'b0, "R9", sda_pull_o, 0);
    stop_c;
  endtask

  task automatic do_read(input logic [7:0] a, input int n);
    bit ack;
    start_c;
    send_byte(DEV_W, ack); chk(ack, "R3", ack, 1);
    send_byte(8'h00, ack); chk(ack, "R4", ack, 1);
    send_byte(a, ack); chk(ack, "R4", ack, 1);
    start_c;
    send_byte(DEV_R, ack); chk(ack, "R3", ack, 1);
    read_tail(a, n);
  endtask

  task automatic cur_read(input logic [7:0] a, input int n);
    bit ack;
    start_c;
    send_byte(DEV_R, ack); chk(ack, "R3", ack, 1);
    read_tail(a, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 256; i++) model[i] = '0;
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R9 / R10 reset state
    chk(sda_pull_o == 1'b0, "R9", sda_pull_o, 0);
    chk(standby_o == 1'b1, "R10", standby_o, 1);

    // R1: a matching address clocked in without a start is ignored
    tick(Q); scl_m = 1'b0;
    send_byte(DEV_W, ack); chk(!ack, "R1", ack, 0);

    // R2: foreign type code, then foreign strap value
    start_c;
    send_byte({4'b1011, STRAP, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2", ack, 0);
    stop_c;
    start_c;
    send_byte({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    stop_c;

    // R4/R5 fill the whole array by page writes, value = 7*addr+3
    for (int p = 0; p < 8; p++)
      do_write(16'(p * 32), 32, 8'(p * 32 * 7 + 3), 8'd7, 1'b1, "R4");
    // R7 sequential read across the array end, last byte wraps to address 0
    do_read(8'h00, 257);

    // R4 high word-address bits beyond the array are ignored
    do_write(16'h7F12, 1, 8'h5A, 8'd0, 1'b1, "R4");
    do_read(8'h12, 1);
    // R3 current-address read continues from the pointer (0x13)
    cur_read(8'h13, 2);

    // R5 page write wraps inside the page
    do_write(16'h003E, 4, 8'hA0, 8'd1, 1'b1, "R5");
    do_read(8'h3E, 2);
    do_read(8'h20, 3);
    chk(model[8'h20] == 8'hA2, "R5", model[8'h20], 8'hA2);

    // R6 write protect covers only the upper half
    wp_i = 1'b1;
    do_write(16'h0090, 1, 8'h11, 8'd0, 1'b0, "R6");
    do_read(8'h90, 1);
    do_write(16'h0010, 1, 8'h22, 8'd0, 1'b1, "R6");
    do_read(8'h10, 1);
    do_read(8'hF0, 2);
    wp_i = 1'b0;

    // R1 repeated start in the middle of a byte
    start_c;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_read(8'h55, 1);

    chk(r8_bad == 0, "R8", r8_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule